// File: doc/BRIEF.md
# Configuration Upset Injection and Comparison Harness

This block runs two copies of one small netlist of input buffers, lookup tables and output buffers from the same stimulus. One copy stays fault-free and serves as the reference. The other copy takes emulated configuration upsets. The stimulus is a pseudo-random input vector, and each bit of it is high with its own programmed probability. On every clock cycle each healthy component of the second copy can be hit, with a probability set for its component type. A buffer that is hit locks its output. A lookup table that is hit has one of its configuration bits inverted, and that bit is picked at random. A shared counter stops injection once the programmed fault limit is reached. In every cycle the outputs of the two copies are compared, and a cycle in which they differ is counted as a failure. After the programmed number of cycles the run stops and the counters hold their values until reset. The failure fraction is then the failure count divided by the run length.

The netlist has NIN input buffers and NLUT lookup tables with LUT_K inputs each, followed by NLUT output buffers. Lookup table j reads buffered inputs (j+t) mod NIN as address bit t. Component indices run over the input buffers first (0..NIN-1), then the lookup tables (NIN..NIN+NLUT-1), then the output buffers. A probability threshold is a 16-bit value. A draw from an independent LFSR fires when it is below the threshold, and the value 16'hFFFF always fires. The control sequencer has three states: `ST_IDLE`, `ST_RUN` and `ST_DONE`. Its transitions are: *launch* (`ST_IDLE` to `ST_RUN` on start with a run length above zero), *empty run* (`ST_IDLE` to `ST_DONE` on start with a run length of zero), *step* (`ST_RUN` to `ST_RUN` while cycles remain), *finish* (`ST_RUN` to `ST_DONE` on the last cycle) and *park* (`ST_DONE` stays in `ST_DONE` until reset).

Top module: `seu_harness`

## Requirements
- R1: After reset, busy and done are 0, both counters are 0 and no component is marked faulty.
- R2: Stimulus bit i is high when its draw is below its threshold `in_thr[16*i+15:16*i]`. A threshold of 16'h0000 always gives 0 and 16'hFFFF always gives 1. Both copies receive the same vector.
- R3: Bit a of the configuration of lookup table j is parity(a) XOR parity(j). The reference output j equals the configuration bit selected by the address formed from the stimulus.
- R4: An input or output buffer that is hit in a cycle holds, from the next cycle on, the value it carried in that cycle, and it ignores all later changes.
- R5: A lookup table that is hit has exactly one configuration bit inverted. From the next cycle on, its output differs from the fault-free value only when its address selects that bit.
- R6: The bits of `fault_mask` (bit index = component index) never fall before reset. A component that is already faulty is never hit again.
- R7: `fault_cnt` equals the number of faulty components and never exceeds `fault_max`.
- R8: Within a cycle, qualifying components are taken in ascending index order. A threshold of 16'h0000 (`thr_lut` for lookup tables, `thr_buf` for buffers) never hits, and 16'hFFFF always hits while the limit allows.
- R9: `mismatch` is high in a run cycle exactly when at least one output bit differs between the copies, and `fail_cnt` counts those cycles. A fault injected in a cycle affects the comparison only from the next cycle on.
- R10: After start, exactly `run_len` run cycles take place and then done rises. A run length of 0 raises done one cycle after start.
- R11: Once done is high, `start` is ignored, and the counters, the fault mask and the outputs of both copies stay unchanged until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run from idle |
| run_len | input | CNT_W | Number of run cycles N |
| fault_max | input | FC_W | Global fault limit F |
| in_thr | input | 16*NIN | Per-input high-probability thresholds |
| thr_lut | input | 16 | Upset threshold for lookup tables |
| thr_buf | input | 16 | Upset threshold for buffers |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail_cnt | output | CNT_W | Cycles with differing outputs |
| fault_cnt | output | FC_W | Faults injected so far |
| fault_mask | output | NCOMP | Faulty flag per component |
| stim | output | NIN | Current shared input vector |
| gold_out | output | NLUT | Reference copy outputs |
| dut_out | output | NLUT | Upset copy outputs |
| mismatch | output | 1 | Copies differ in this cycle |

## Verification
The assertions assume that `run_len`, `fault_max` and the thresholds stay constant from start until reset. They also assume that `fault_max` is no larger than the number of components. The stimulus programs every setting while the block is idle and resets it between runs. It then drives only `start`, which also shows that start has no effect after done. The fault thresholds are set to 0 or 16'hFFFF only, so the bench can predict which components are hit. The randomly chosen lookup-table bit is learned from the outputs and then held to for the rest of the run.

// File: rtl/seu_pkg.sv
package seu_pkg;

    localparam int THR_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } run_state_e;

    // Bernoulli event: draw below threshold, all-ones threshold is certain
    function automatic logic bern(input logic [THR_W-1:0] draw,
                                  input logic [THR_W-1:0] thr);
        return (thr == {THR_W{1'b1}}) || (draw < thr);
    endfunction

    // Distinct non-zero seed per generator
    function automatic logic [31:0] lfsr_seed(input int idx);
        logic [31:0] s;
        s = 32'h9E37_79B9 ^ (32'(idx + 1) * 32'h0100_0193);
        return s | 32'h1;
    endfunction

    // Fault-free configuration bit of lookup table lut at address addr
    function automatic logic cfg_bit(input int lut, input int addr);
        logic [31:0] a;
        logic [31:0] l;
        a = 32'(addr);
        l = 32'(lut);
        return (^a) ^ (^l);
    endfunction

endpackage

// File: rtl/seu_lfsr.sv
module seu_lfsr #(
    parameter int          OUT_W = 16,
    parameter logic [31:0] SEED  = 32'h1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] draw
);

    logic [31:0] state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (state[0]) begin
            state <= (state >> 1) ^ 32'h8020_0003;
        end else begin
            state <= state >> 1;
        end
    end

    assign draw = state[OUT_W-1:0];

endmodule

// File: rtl/seu_netlist.sv
module seu_netlist import seu_pkg::*; #(
    parameter int NIN   = 4,
    parameter int NLUT  = 4,
    parameter int LUT_K = 2,
    localparam int LUT_W = 1 << LUT_K
) (
    input  logic [NIN-1:0]             stim,
    input  logic [NIN-1:0]             ibuf_bad,
    input  logic [NIN-1:0]             ibuf_frz,
    input  logic [NLUT-1:0][LUT_W-1:0] lut_flip,
    output logic [NLUT-1:0]            lut_val
);

    logic [NIN-1:0] ibuf_val;

    // input buffers: a frozen buffer drives its captured value
    assign ibuf_val = (ibuf_bad & ibuf_frz) | (~ibuf_bad & stim);

    for (genvar j = 0; j < NLUT; j++) begin : g_lut
        logic [LUT_K-1:0] addr;
        logic [LUT_W-1:0] cfg;

        for (genvar t = 0; t < LUT_K; t++) begin : g_addr
            assign addr[t] = ibuf_val[(j + t) % NIN];
        end

        always_comb begin
            for (int a = 0; a < LUT_W; a++) begin
                cfg[a] = cfg_bit(j, a) ^ lut_flip[j][a];
            end
        end

        assign lut_val[j] = cfg[addr];
    end

endmodule

// File: rtl/seu_inject.sv
module seu_inject import seu_pkg::*; #(
    parameter int NIN   = 4,
    parameter int NLUT  = 4,
    parameter int LUT_K = 2,
    parameter int FC_W  = 4,
    localparam int NCOMP = NIN + 2 * NLUT,
    localparam int NBUF  = NIN + NLUT,
    localparam int LUT_W = 1 << LUT_K
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             en,
    input  logic [FC_W-1:0]                  fault_max,
    input  logic [THR_W-1:0]                 thr_lut,
    input  logic [THR_W-1:0]                 thr_buf,
    input  logic [NBUF-1:0][THR_W-1:0]       draw_buf,
    input  logic [NLUT-1:0][THR_W+LUT_K-1:0] draw_lut,
    input  logic [NIN-1:0]                   cur_in,
    input  logic [NLUT-1:0]                  cur_lut,
    output logic [NCOMP-1:0]                 bad,
    output logic [NIN-1:0]                   ibuf_frz,
    output logic [NLUT-1:0]                  obuf_frz,
    output logic [NLUT-1:0][LUT_W-1:0]       lut_flip,
    output logic [FC_W-1:0]                  fault_cnt
);

    logic [NCOMP-1:0] hit;
    logic [NCOMP-1:0] inj;
    logic [FC_W-1:0]  cnt_n;

    // per-component Bernoulli draws, indices ordered in-buf, LUT, out-buf
    for (genvar i = 0; i < NIN; i++) begin : g_hit_in
        assign hit[i] = bern(draw_buf[i], thr_buf);
    end
    for (genvar j = 0; j < NLUT; j++) begin : g_hit_lut
        assign hit[NIN+j]      = bern(draw_lut[j][THR_W-1:0], thr_lut);
        assign hit[NIN+NLUT+j] = bern(draw_buf[NIN+j], thr_buf);
    end

    // ascending-index grant under the global cap
    always_comb begin
        cnt_n = fault_cnt;
        inj   = '0;
        for (int i = 0; i < NCOMP; i++) begin
            if (en && !bad[i] && hit[i] && (cnt_n < fault_max)) begin
                inj[i] = 1'b1;
                cnt_n  = cnt_n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad       <= '0;
            fault_cnt <= '0;
        end else begin
            bad       <= bad | inj;
            fault_cnt <= cnt_n;
        end
    end

    for (genvar i = 0; i < NIN; i++) begin : g_frz_in
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ibuf_frz[i] <= 1'b0;
            end else if (inj[i]) begin
                ibuf_frz[i] <= cur_in[i];
            end
        end

        a_r4_in_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            $past(bad[i]) |-> $stable(ibuf_frz[i]));
    end

    for (genvar j = 0; j < NLUT; j++) begin : g_frz_lut
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                obuf_frz[j] <= 1'b0;
                lut_flip[j] <= '0;
            end else begin
                if (inj[NIN+NLUT+j]) begin
                    obuf_frz[j] <= cur_lut[j];
                end
                if (inj[NIN+j]) begin
                    lut_flip[j] <= LUT_W'(1) << draw_lut[j][THR_W +: LUT_K];
                end
            end
        end

        a_r5_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(lut_flip[j]) == (bad[NIN+j] ? 1 : 0));

        a_r4_out_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            $past(bad[NIN+NLUT+j]) |-> $stable(obuf_frz[j]));
    end

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bad & $past(bad)) == $past(bad));

    a_r7_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fault_cnt) == $countones(bad));

    a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cnt <= fault_max) && $stable(fault_max) |=> fault_cnt <= fault_max);

endmodule

// File: rtl/seu_harness.sv
module seu_harness import seu_pkg::*; #(
    parameter int NIN   = 4,
    parameter int NLUT  = 4,
    parameter int LUT_K = 2,
    parameter int CNT_W = 16,
    localparam int NCOMP = NIN + 2 * NLUT,
    localparam int FC_W  = $clog2(NCOMP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   run_len,
    input  logic [FC_W-1:0]    fault_max,
    input  logic [16*NIN-1:0]  in_thr,
    input  logic [15:0]        thr_lut,
    input  logic [15:0]        thr_buf,
    output logic               busy,
    output logic               done,
    output logic [CNT_W-1:0]   fail_cnt,
    output logic [FC_W-1:0]    fault_cnt,
    output logic [NCOMP-1:0]   fault_mask,
    output logic [NIN-1:0]     stim,
    output logic [NLUT-1:0]    gold_out,
    output logic [NLUT-1:0]    dut_out,
    output logic               mismatch
);

    localparam int NBUF  = NIN + NLUT;
    localparam int LUT_W = 1 << LUT_K;

    run_state_e state, state_n;
    logic [CNT_W-1:0] cyc;
    logic go, running, last;

    logic [NIN-1:0]                   stim_q, stim_n;
    logic [NIN-1:0][THR_W-1:0]        draw_in;
    logic [NBUF-1:0][THR_W-1:0]       draw_buf;
    logic [NLUT-1:0][THR_W+LUT_K-1:0] draw_lut;

    logic [NCOMP-1:0]            bad;
    logic [NIN-1:0]              ibuf_frz;
    logic [NLUT-1:0]             obuf_frz;
    logic [NLUT-1:0][LUT_W-1:0]  lut_flip;
    logic [NLUT-1:0]             gold_lut, dut_lut, dut_o;

    // ---------------- random sources ----------------
    for (genvar g = 0; g < NIN; g++) begin : g_src_in
        seu_lfsr #(.OUT_W(THR_W), .SEED(lfsr_seed(g))) u_lfsr (
            .clk(clk), .rst_n(rst_n), .draw(draw_in[g]));
        assign stim_n[g] = bern(draw_in[g], in_thr[g*THR_W +: THR_W]);
    end
    for (genvar g = 0; g < NBUF; g++) begin : g_src_buf
        seu_lfsr #(.OUT_W(THR_W), .SEED(lfsr_seed(NIN + g))) u_lfsr (
            .clk(clk), .rst_n(rst_n), .draw(draw_buf[g]));
    end
    for (genvar g = 0; g < NLUT; g++) begin : g_src_lut
        seu_lfsr #(.OUT_W(THR_W + LUT_K), .SEED(lfsr_seed(NIN + NBUF + g))) u_lfsr (
            .clk(clk), .rst_n(rst_n), .draw(draw_lut[g]));
    end

    // ---------------- sequencer ----------------
    assign go      = (state == ST_IDLE) && start;
    assign running = (state == ST_RUN);
    assign last    = running && (cyc == run_len - 1'b1);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (start) state_n = (run_len == '0) ? ST_DONE : ST_RUN;
            ST_RUN:  if (last)  state_n = ST_DONE;
            ST_DONE: state_n = ST_DONE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stim_q   <= '0;
            cyc      <= '0;
            fail_cnt <= '0;
        end else begin
            if (go || running) stim_q <= stim_n;
            if (go)            cyc    <= '0;
            if (running) begin
                cyc <= cyc + 1'b1;
                if (mismatch) fail_cnt <= fail_cnt + 1'b1;
            end
        end
    end

    // ---------------- the two copies ----------------
    seu_netlist #(.NIN(NIN), .NLUT(NLUT), .LUT_K(LUT_K)) u_gold (
        .stim(stim_q), .ibuf_bad('0), .ibuf_frz('0), .lut_flip('0),
        .lut_val(gold_lut));

    seu_netlist #(.NIN(NIN), .NLUT(NLUT), .LUT_K(LUT_K)) u_dut (
        .stim(stim_q), .ibuf_bad(bad[NIN-1:0]), .ibuf_frz(ibuf_frz),
        .lut_flip(lut_flip), .lut_val(dut_lut));

    for (genvar j = 0; j < NLUT; j++) begin : g_obuf
        assign dut_o[j] = bad[NIN+NLUT+j] ? obuf_frz[j] : dut_lut[j];
    end

    seu_inject #(.NIN(NIN), .NLUT(NLUT), .LUT_K(LUT_K), .FC_W(FC_W)) u_inject (
        .clk(clk), .rst_n(rst_n), .en(running), .fault_max(fault_max),
        .thr_lut(thr_lut), .thr_buf(thr_buf), .draw_buf(draw_buf),
        .draw_lut(draw_lut), .cur_in(stim_q), .cur_lut(dut_lut),
        .bad(bad), .ibuf_frz(ibuf_frz), .obuf_frz(obuf_frz),
        .lut_flip(lut_flip), .fault_cnt(fault_cnt));

    // ---------------- outputs ----------------
    assign busy       = running;
    assign done       = (state == ST_DONE);
    assign fault_mask = bad;
    assign stim       = stim_q;
    assign gold_out   = gold_lut;
    assign dut_out    = dut_o;
    assign mismatch   = running && (gold_lut != dut_o);

    a_r10_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        running && $stable(run_len) |-> cyc < run_len);

    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(fail_cnt));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && $stable(fail_cnt) && $stable(fault_cnt) && $stable(fault_mask));

    a_r9_fail_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running && $stable(run_len) |-> fail_cnt <= cyc);

endmodule

// File: tb/tb_seu_harness.sv
module tb_seu_harness;

    localparam int CLK_PERIOD = 10;
    localparam int NIN   = 4;
    localparam int NLUT  = 4;
    localparam int LUT_K = 2;
    localparam int CNT_W = 16;
    localparam int NC    = NIN + 2 * NLUT;
    localparam int FC_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0]  run_len = '0;
    logic [FC_W-1:0]   fault_max = '0;
    logic [16*NIN-1:0] in_thr = '0;
    logic [15:0]       thr_lut = '0;
    logic [15:0]       thr_buf = '0;
    logic              busy, done, mismatch;
    logic [CNT_W-1:0]  fail_cnt;
    logic [FC_W-1:0]   fault_cnt;
    logic [NC-1:0]     fault_mask;
    logic [NIN-1:0]    stim;
    logic [NLUT-1:0]   gold_out, dut_out;

    seu_harness dut (
        .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len),
        .fault_max(fault_max), .in_thr(in_thr), .thr_lut(thr_lut),
        .thr_buf(thr_buf), .busy(busy), .done(done), .fail_cnt(fail_cnt),
        .fault_cnt(fault_cnt), .fault_mask(fault_mask), .stim(stim),
        .gold_out(gold_out), .dut_out(dut_out), .mismatch(mismatch));

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit cfgb(input int j, input int a);
        return bit'(($countones(a) + $countones(j)) % 2);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(!busy && !done, "R1 flags", {busy, done}, 0);
        chk(fail_cnt == 0 && fault_cnt == 0, "R1 counters", {fail_cnt, fault_cnt}, 0);
        chk(fault_mask == 0, "R1 mask", fault_mask, 0);
    endtask

    task automatic run_case(input int n, input int f, input logic [15:0] pl,
                            input logic [15:0] pb, input logic [63:0] it,
                            input bit need_learn);
        logic [NC-1:0]   emask;
        int              ecnt, efail, ad, gad, cnt;
        logic [NIN-1:0]  ifrz, eff;
        logic [NLUT-1:0] ofrz, lutv, expo, gexp;
        int              learned [NLUT];
        logic [CNT_W-1:0] hold_fail;
        logic [NC-1:0]    hold_mask;

        do_reset();
        run_len   = CNT_W'(n);
        fault_max = FC_W'(f);
        thr_lut   = pl;
        thr_buf   = pb;
        in_thr    = it;
        emask = '0; ecnt = 0; efail = 0; ifrz = '0; ofrz = '0;
        for (int j = 0; j < NLUT; j++) learned[j] = -1;

        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n; k++) begin
            chk(busy && !done, "R10 busy during run", {busy, done}, 2'b10);
            chk(fault_mask == emask, "R8 fault mask", fault_mask, emask);
            chk(32'(fault_cnt) == ecnt, "R7 fault count", fault_cnt, ecnt);
            for (int i = 0; i < NIN; i++) begin
                if (it[16*i +: 16] == 16'hFFFF) chk(stim[i], "R2 certain high", stim[i], 1);
                if (it[16*i +: 16] == 16'h0000) chk(!stim[i], "R2 never high", stim[i], 0);
                eff[i] = emask[i] ? ifrz[i] : stim[i];
            end
            for (int j = 0; j < NLUT; j++) begin
                gad = 0; ad = 0;
                for (int t = 0; t < LUT_K; t++) begin
                    gad |= int'(stim[(j + t) % NIN]) << t;
                    ad  |= int'(eff[(j + t) % NIN]) << t;
                end
                gexp[j] = cfgb(j, gad);
                lutv[j] = cfgb(j, ad);
                if (emask[NIN+j]) begin
                    if (learned[j] < 0 && !emask[NIN+NLUT+j] && dut_out[j] != lutv[j])
                        learned[j] = ad;
                    if (learned[j] == ad) lutv[j] = ~lutv[j];
                end
                expo[j] = emask[NIN+NLUT+j] ? ofrz[j] : lutv[j];
            end
            chk(gold_out == gexp, "R3 reference outputs", gold_out, gexp);
            chk(dut_out == expo, "R4/R5 upset copy outputs", dut_out, expo);
            chk(mismatch == (expo != gexp), "R9 mismatch flag", mismatch, expo != gexp);
            if (expo != gexp) efail++;
            // expected injection at the end of this cycle
            cnt = ecnt;
            for (int i = 0; i < NC; i++) begin
                if (!emask[i] && (((i >= NIN) && (i < NIN + NLUT)) ? pl : pb) == 16'hFFFF
                    && cnt < f) begin
                    emask[i] = 1'b1;
                    cnt++;
                    if (i < NIN) ifrz[i] = eff[i];
                    else if (i >= NIN + NLUT) ofrz[i-NIN-NLUT] = lutv[i-NIN-NLUT];
                end
            end
            ecnt = cnt;
            @(negedge clk);
        end
        chk(done && !busy, "R10 done after run length", {busy, done}, 2'b01);
        chk(32'(fail_cnt) == efail, "R9 failure count", fail_cnt, efail);
        chk(32'(fault_cnt) == ecnt, "R7 final fault count", fault_cnt, ecnt);
        if (need_learn) chk(learned[0] >= 0, "R5 flipped bit observed", learned[0], 0);
        // R11: start ignored once done
        hold_fail = fail_cnt;
        hold_mask = fault_mask;
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(done && !busy, "R11 stays done", {busy, done}, 2'b01);
        chk(fail_cnt == hold_fail && fault_mask == hold_mask, "R11 counters hold",
            {fail_cnt, fault_mask}, {hold_fail, hold_mask});
    endtask

    initial begin
        // no faults, random inputs
        run_case(40, 12, 16'h0000, 16'h0000, {4{16'h8000}}, 1'b0);
        // two input buffers frozen, fixed bits on inputs 2 and 3 (R2, R4)
        run_case(30, 2, 16'h0000, 16'hFFFF, {16'hFFFF, 16'h0000, 16'h8000, 16'h8000}, 1'b0);
        // limit of zero blocks everything (R7)
        run_case(20, 0, 16'hFFFF, 16'hFFFF, {4{16'h8000}}, 1'b0);
        // one lookup-table upset (R5)
        run_case(60, 1, 16'hFFFF, 16'h0000, {4{16'h8000}}, 1'b1);
        // every buffer frozen, lookup tables spared (R4, R8)
        run_case(20, 12, 16'h0000, 16'hFFFF, {4{16'h8000}}, 1'b0);
        // cap cuts the ascending order after five components (R7, R8)
        run_case(20, 5, 16'hFFFF, 16'hFFFF, {4{16'h8000}}, 1'b0);
        // empty run (R10)
        run_case(0, 3, 16'hFFFF, 16'hFFFF, {4{16'h8000}}, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule